// File: doc/BRIEF.md
# SPI Transmit Queue Write Port with Sticky Control Word

This block is the transmit-side write port of an SPI controller. Software writes to a single 32-bit register location. Each write is sorted by its byte strobes and by whether its upper half-word is non-zero. The result is one of three actions: load a persistent 12-bit control word, push a 16-bit data word into the transmit queue, or load the control word and push in the same cycle. Every queue entry carries the data word together with the control word that applied when it was pushed. The serial shifter can therefore change per-transfer settings without any separate register access.

The queue is eight entries deep. The shifter pops it with a single-cycle strobe, and it shows the head entry's data and control bits at all times. Empty and full flags report its fill. A registered refill request rises when the occupancy is at or below a programmable level, so one service routine can top up several entries at once. A push that finds the queue full is dropped and latches a sticky overflow flag, which a dedicated clear input resets. Reads of the port return zero.

The occupancy is tracked by a three-state machine: `FS_EMPTY`, `FS_PARTIAL` and `FS_FULL`.
- `FS_EMPTY` goes to `FS_PARTIAL` on an accepted push.
- `FS_PARTIAL` goes to `FS_FULL` when a push without a pop fills the last slot.
- `FS_PARTIAL` returns to `FS_EMPTY` when a pop without a push takes the last entry.
- `FS_FULL` goes back to `FS_PARTIAL` on any pop.

Each write is classified as one of four kinds:
- `WK_NONE`: ignored.
- `WK_CTRL_ONLY`: upper half-word only.
- `WK_DATA`: byte or lower half-word.
- `WK_WORD`: full word.

Top module: `spi_txq_wrport`

## Requirements
- R1: A write with strobes 4'b1100 at the port's word address pushes nothing. If wr_data[31:16] is non-zero it loads the control word from wr_data[27:16]. If wr_data[31:16] is zero the control word is left unchanged.
- R2: A write with strobes 4'b0001, 4'b0010 or 4'b0011 pushes one entry. The entry's data is wr_data[15:0] with the byte lanes that are not strobed forced to zero, and its control bits are the current control word.
- R3: A full-word write (strobes 4'b1111) whose wr_data[31:16] is zero pushes wr_data[15:0] with the current control word and leaves the control word unchanged.
- R4: A full-word write whose wr_data[31:16] is non-zero loads the control word from wr_data[27:16] and pushes wr_data[15:0] carrying that new control word, in the same cycle.
- R5: A write with any other strobe pattern, or with wr_addr[ADDR_W-1:2] different from WORD_IDX, changes neither the queue nor the control word.
- R6: rd_data is always zero, whatever has been written.
- R7: The queue holds DEPTH entries in first-in first-out order. head_data and head_ctrl show the oldest entry. fifo_empty and fifo_full are never high together.
- R8: level_req is registered. After each clock edge it is high exactly when the occupancy after that edge is at most tx_level.
- R9: A push while fifo_full is high is dropped and sets ovf_flag. ovf_flag stays high until ovf_clr is pulsed; a new overflow in the same cycle wins over the clear.
- R10: A pop while the queue is empty has no effect.
- R11: Reset empties the queue, clears the control word to zero, and holds level_req and ovf_flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write valid |
| wr_addr | input | ADDR_W | Byte address within the port window |
| wr_strb | input | 4 | Byte-lane strobes |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Bus read valid |
| rd_data | output | 32 | Read data, always zero |
| tx_level | input | $clog2(DEPTH) | Refill threshold |
| pop | input | 1 | Single-cycle pop strobe from the shifter |
| head_data | output | 16 | Data bits of the oldest entry |
| head_ctrl | output | CTRL_W | Control bits of the oldest entry |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| level_req | output | 1 | Refill request |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears ovf_flag |

## Verification
The bench builds the block with its defaults: DEPTH of 8, CTRL_W of 12, ADDR_W of 4 and WORD_IDX of 0. With eight entries, the full and overflow corners are reached within nine pushes. The 3-bit level lets the request edge be crossed at an intermediate occupancy of two. The 4-bit address gives a second word address (4'h4), which is used to prove that writes outside the port are ignored.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;

    localparam int BUS_W    = 32;
    localparam int HALF_W   = 16;
    localparam int CTRL_LSB = 16;

    typedef enum logic [1:0] {
        WK_NONE      = 2'd0,
        WK_CTRL_ONLY = 2'd1,
        WK_DATA      = 2'd2,
        WK_WORD      = 2'd3
    } wr_kind_e;

    typedef enum logic [1:0] {
        FS_EMPTY   = 2'd0,
        FS_PARTIAL = 2'd1,
        FS_FULL    = 2'd2
    } fill_state_e;

endpackage

// File: rtl/spi_txq_decode.sv
module spi_txq_decode
    import spi_txq_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int WORD_IDX = 0,
    parameter int CTRL_W   = 12
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_strb,
    input  logic [BUS_W-1:0]  wr_data,
    output logic              push,
    output logic              ctrl_load,
    output logic [CTRL_W-1:0] ctrl_new,
    output logic [HALF_W-1:0] data_out
);

    localparam logic [ADDR_W-3:0] WORD_SEL = WORD_IDX[ADDR_W-3:0];

    wr_kind_e kind;
    logic     hit;
    logic     upper_nz;

    assign hit      = wr_en && (wr_addr[ADDR_W-1:2] == WORD_SEL);
    assign upper_nz = |wr_data[BUS_W-1:HALF_W];

    always_comb begin
        kind = WK_NONE;
        if (hit) begin
            unique case (wr_strb)
                4'b1100:                   kind = WK_CTRL_ONLY;
                4'b0001, 4'b0010, 4'b0011: kind = WK_DATA;
                4'b1111:                   kind = WK_WORD;
                default:                   kind = WK_NONE;
            endcase
        end
    end

    always_comb begin
        push      = (kind == WK_DATA) || (kind == WK_WORD);
        ctrl_load = ((kind == WK_CTRL_ONLY) || (kind == WK_WORD)) && upper_nz;
        ctrl_new  = wr_data[CTRL_LSB +: CTRL_W];
        data_out  = {wr_strb[1] ? wr_data[15:8] : 8'h00,
                     wr_strb[0] ? wr_data[7:0]  : 8'h00};
    end

endmodule

// File: rtl/spi_txq_ctrl_reg.sv
module spi_txq_ctrl_reg #(
    parameter int CTRL_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CTRL_W-1:0] new_val,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [CTRL_W-1:0] ctrl_eff
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ctrl_q <= '0;
        else if (load) ctrl_q <= new_val;
    end

    // A loading write pushes with its own new value in the same cycle.
    assign ctrl_eff = load ? new_val : ctrl_q;

endmodule

// File: rtl/spi_txq_fifo.sv
module spi_txq_fifo
    import spi_txq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic             empty,
    output logic             full,
    output logic             overflow_evt,
    output logic [$clog2(DEPTH+1)-1:0] cnt_next
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ALMOST   = CNT_W'(DEPTH - 1);

    fill_state_e state, state_nx;
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign do_push = push_req && (state != FS_FULL);
    assign do_pop  = pop_req  && (state != FS_EMPTY);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_EMPTY;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            FS_EMPTY: begin
                if (do_push) state_nx = FS_PARTIAL;
            end
            FS_PARTIAL: begin
                if (do_push && !do_pop && cnt == ALMOST)
                    state_nx = FS_FULL;
                else if (do_pop && !do_push && cnt == CNT_W'(1))
                    state_nx = FS_EMPTY;
            end
            FS_FULL: begin
                if (do_pop) state_nx = FS_PARTIAL;
            end
            default: state_nx = FS_EMPTY;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        empty        = (state == FS_EMPTY);
        full         = (state == FS_FULL);
        overflow_evt = push_req && (state == FS_FULL);
    end

    assign cnt_next = cnt + CNT_W'(do_push) - CNT_W'(do_pop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            cnt <= cnt_next;
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];

endmodule

// File: rtl/spi_txq_level.sv
module spi_txq_level #(
    parameter int CNT_W = 4,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [LVL_W-1:0] level,
    input  logic             ovf_set,
    input  logic             ovf_clr,
    output logic             req,
    output logic             ovf
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req <= 1'b0;
            ovf <= 1'b0;
        end else begin
            req <= (cnt_next <= CNT_W'(level));
            if (ovf_set)      ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_txq_wrport.sv
module spi_txq_wrport
    import spi_txq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int CTRL_W   = 12,
    parameter int ADDR_W   = 4,
    parameter int WORD_IDX = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [3:0]               wr_strb,
    input  logic [BUS_W-1:0]         wr_data,
    input  logic                     rd_en,
    output logic [BUS_W-1:0]         rd_data,
    input  logic [$clog2(DEPTH)-1:0] tx_level,
    input  logic                     pop,
    output logic [HALF_W-1:0]        head_data,
    output logic [CTRL_W-1:0]        head_ctrl,
    output logic                     fifo_empty,
    output logic                     fifo_full,
    output logic                     level_req,
    output logic                     ovf_flag,
    input  logic                     ovf_clr
);

    localparam int LVL_W   = $clog2(DEPTH);
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int ENTRY_W = HALF_W + CTRL_W;

    logic                dec_push;
    logic                ctrl_load;
    logic [CTRL_W-1:0]   ctrl_new;
    logic [HALF_W-1:0]   push_data;
    logic [CTRL_W-1:0]   ctrl_cur;
    logic [CTRL_W-1:0]   ctrl_eff;
    logic [ENTRY_W-1:0]  head_entry;
    logic                ovf_evt;
    logic [CNT_W-1:0]    cnt_next;
    logic                unused_read;

    spi_txq_decode #(
        .ADDR_W(ADDR_W), .WORD_IDX(WORD_IDX), .CTRL_W(CTRL_W)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb), .wr_data(wr_data),
        .push(dec_push), .ctrl_load(ctrl_load), .ctrl_new(ctrl_new),
        .data_out(push_data)
    );

    spi_txq_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load(ctrl_load), .new_val(ctrl_new),
        .ctrl_q(ctrl_cur), .ctrl_eff(ctrl_eff)
    );

    spi_txq_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_req(dec_push), .pop_req(pop),
        .wdata({ctrl_eff, push_data}), .rdata(head_entry),
        .empty(fifo_empty), .full(fifo_full), .overflow_evt(ovf_evt),
        .cnt_next(cnt_next)
    );

    spi_txq_level #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_lvl (
        .clk(clk), .rst_n(rst_n), .cnt_next(cnt_next), .level(tx_level),
        .ovf_set(ovf_evt), .ovf_clr(ovf_clr), .req(level_req), .ovf(ovf_flag)
    );

    assign head_data   = head_entry[HALF_W-1:0];
    assign head_ctrl   = head_entry[ENTRY_W-1:HALF_W];
    assign rd_data     = '0;
    assign unused_read = rd_en;

endmodule

// File: rtl/spi_txq_checker.sv
module spi_txq_checker #(
    parameter int CTRL_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        wr_strb,
    input logic              pop,
    input logic              ovf_clr,
    input logic              fifo_empty,
    input logic              fifo_full,
    input logic              level_req,
    input logic              ovf_flag,
    input logic              dec_push,
    input logic [CTRL_W-1:0] ctrl_cur
);

    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty)); // R7
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_cur)); // R1
    AST_UPPER_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb == 4'b1100) |-> !dec_push); // R1
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !pop) |=> fifo_full); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R9
    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && !dec_push) |=> fifo_empty); // R10
    AST_REQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && fifo_empty) |-> level_req); // R8

endmodule

bind spi_txq_wrport spi_txq_checker #(.CTRL_W(CTRL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_strb(wr_strb), .pop(pop),
    .ovf_clr(ovf_clr), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .level_req(level_req), .ovf_flag(ovf_flag), .dec_push(dec_push),
    .ctrl_cur(ctrl_cur)
);

// File: tb/tb_spi_txq_wrport.sv
module tb_spi_txq_wrport;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  strb;
        logic [31:0] data;
        logic        push;
        logic [15:0] edata;
        logic [11:0] ectrl;
    } vec_t;

    // Control word carries over from one row to the next.
    localparam vec_t VECS [0:11] = '{
        '{4'b0011, 32'h0000_1234, 1'b1, 16'h1234, 12'h000}, // R2
        '{4'b1100, 32'h0ABC_0000, 1'b0, 16'h0000, 12'h000}, // R1 load ABC
        '{4'b0011, 32'h0000_5555, 1'b1, 16'h5555, 12'hABC}, // R2
        '{4'b1111, 32'h0000_7777, 1'b1, 16'h7777, 12'hABC}, // R3
        '{4'b1111, 32'h0123_8888, 1'b1, 16'h8888, 12'h123}, // R4
        '{4'b1100, 32'h0000_FFFF, 1'b0, 16'h0000, 12'h000}, // R1 zero keeps
        '{4'b0001, 32'hFFFF_FFA5, 1'b1, 16'h00A5, 12'h123}, // R2 lane0
        '{4'b0010, 32'hFFFF_5AFF, 1'b1, 16'h5A00, 12'h123}, // R2 lane1
        '{4'b0100, 32'h00FF_0000, 1'b0, 16'h0000, 12'h000}, // R5 bad strobe
        '{4'b0011, 32'h0000_0001, 1'b1, 16'h0001, 12'h123}, // R5 ctrl kept
        '{4'b1100, 32'hF000_0000, 1'b0, 16'h0000, 12'h000}, // R1 loads 000
        '{4'b0011, 32'h0000_2222, 1'b1, 16'h2222, 12'h000}  // R1 ctrl now 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [3:0]  wr_strb = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [2:0]  tx_level = '0;
    logic        pop = 1'b0;
    logic [15:0] head_data;
    logic [11:0] head_ctrl;
    logic        fifo_empty, fifo_full, level_req, ovf_flag;
    logic        ovf_clr = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_txq_wrport dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_strb(wr_strb), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .tx_level(tx_level), .pop(pop), .head_data(head_data),
        .head_ctrl(head_ctrl), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .level_req(level_req), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_strb = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0;
    endtask

    task automatic do_pop();
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 empty in reset", 32'(fifo_empty), 32'd1);
        check("R11 full in reset", 32'(fifo_full), 32'd0);
        check("R11 req in reset", 32'(level_req), 32'd0);
        check("R11 ovf in reset", 32'(ovf_flag), 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R8 req after reset, level 0", 32'(level_req), 32'd1);

        // Vector walk
        for (int i = 0; i < 12; i++) begin
            do_write(4'h0, VECS[i].strb, VECS[i].data);
            if (VECS[i].push) begin
                check("R2/R3/R4 pushed", 32'(fifo_empty), 32'd0);
                check("R2/R3/R4 head data", 32'(head_data), 32'(VECS[i].edata));
                check("R1/R4 head ctrl", 32'(head_ctrl), 32'(VECS[i].ectrl));
                do_pop();
                check("R7 empty after pop", 32'(fifo_empty), 32'd1);
            end else begin
                check("R1/R5 no push", 32'(fifo_empty), 32'd1);
            end
        end

        // Fill, threshold, overflow, order
        tx_level = 3'd2;
        for (int k = 0; k < 8; k++) begin
            do_write(4'h0, 4'b1111, 32'h1000 + k);
            if (k == 1) check("R8 req at occupancy 2", 32'(level_req), 32'd1);
            if (k == 2) check("R8 req at occupancy 3", 32'(level_req), 32'd0);
        end
        check("R7 full after 8", 32'(fifo_full), 32'd1);
        do_write(4'h0, 4'b0011, 32'h0000_DEAD);
        check("R9 overflow set", 32'(ovf_flag), 32'd1);
        check("R9 still full", 32'(fifo_full), 32'd1);
        @(negedge clk);
        rd_en = 1'b1;
        #1 check("R6 read returns zero", rd_data, 32'd0);
        @(negedge clk);
        rd_en = 1'b0;
        for (int k = 0; k < 8; k++) begin
            check("R7 fifo order", 32'(head_data), 32'h1000 + k);
            do_pop();
        end
        check("R7 empty after drain", 32'(fifo_empty), 32'd1);
        check("R9 overflow sticky", 32'(ovf_flag), 32'd1);
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check("R9 overflow cleared", 32'(ovf_flag), 32'd0);

        // Pop on empty
        do_pop();
        check("R10 still empty", 32'(fifo_empty), 32'd1);
        do_write(4'h0, 4'b0011, 32'h0000_0042);
        check("R10 head after empty pop", 32'(head_data), 32'h42);
        do_pop();
        check("R10 single pop empties", 32'(fifo_empty), 32'd1);

        // Other word address
        do_write(4'h4, 4'b1111, 32'h0FFF_1111);
        check("R5 other address no push", 32'(fifo_empty), 32'd1);
        do_write(4'h0, 4'b0011, 32'h0000_0001);
        check("R5 other address ctrl kept", 32'(head_ctrl), 32'h000);
        do_pop();

        // Reset clears control word
        do_write(4'h0, 4'b1100, 32'h0555_0000);
        do_reset();
        do_write(4'h0, 4'b0011, 32'h0000_0077);
        check("R11 ctrl zero after reset", 32'(head_ctrl), 32'h000);
        check("R11 data after reset", 32'(head_data), 32'h77);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule